// File: doc/BRIEF.md
# Composite Digit-Array Multiplier

This block forms the full product of two operands from an array of narrow 8-bit digit multipliers rather than one wide multiplier. Each operand is cut into base-256 digits. Every digit of one operand is multiplied by every digit of the other. Each partial product is then moved to the weight of its combined digit position and added into the final sum. A per-transaction mode bit selects two's complement or unsigned operands.

In signed mode only the top digit of each operand carries a sign. Every digit multiplier is one bit wider than a digit. A digit that must be read as unsigned has its extra bit forced to zero, so a single signed core covers the signed×signed, signed×unsigned and unsigned×unsigned pairings.

The block has a fixed two-stage pipeline. The first stage registers the partial products. The second stage registers the weighted sum. A new operand pair can be accepted on every cycle, and results leave in the order the operands came in. The operand width is a parameter: 16 bits by default, 32 bits as the wider option.

Top module: `byte_digit_mult`

## Requirements
- R1: With signed_i=1, product_o equals the two's complement product of a_i and b_i, exact over the full 2*OP_W bits.
- R2: With signed_i=0, product_o equals the unsigned product of a_i and b_i, exact over the full 2*OP_W bits.
- R3: valid_o goes high exactly two clock cycles after a cycle in which valid_i is high, and stays low otherwise. Operands accepted on consecutive cycles produce results on consecutive cycles, in input order.
- R4: While valid_o is low, product_o keeps the last result it presented. Operands applied with valid_i=0 do not change it.
- R5: During and after an active-low reset, valid_o is 0 and product_o is 0 until a new result arrives.
- R6: The extremes are exact. Signed 0x8000×0x8000 gives 0x40000000. Signed 0xFFFF×0xFFFF gives 0x00000001. Unsigned 0xFFFF×0xFFFF gives 0xFFFE0001.
- R7: signed_i is captured together with its operands, so transactions of different modes issued back to back each use their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid this cycle |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| a_i | input | OP_W | Multiplicand |
| b_i | input | OP_W | Multiplier |
| valid_o | output | 1 | product_o holds a new result this cycle |
| product_o | output | 2*OP_W | Full-width product |

## Verification
The hardest case to reach is a partial product whose sign bit must reach the top of the sum. That happens only when a signed top digit is paired with a lower digit that has its high bit set, for example 0x00FF×0xFF00 or 0xFF80×0x0080. It also happens when mode changes between adjacent transactions. The vector table places these signed/unsigned twins next to each other and issues them on back-to-back cycles. Any digit that gets the wrong extension, or a mode that leaks between pipeline stages, then shows up directly in the upper product bits.

// File: rtl/mulc_pkg.sv
package mulc_pkg;
  localparam int unsigned DIG_W = 8;

  // bit offset of the partial product for digit pair (i, j)
  function automatic int unsigned pp_shift(int unsigned i, int unsigned j);
    return (i + j) * DIG_W;
  endfunction
endpackage

// File: rtl/mulc_digit_mul.sv
module mulc_digit_mul #(
  parameter int unsigned DIG_W = 8,
  localparam int unsigned P_W  = 2 * DIG_W + 2
) (
  input  logic [DIG_W-1:0]    x_i,
  input  logic [DIG_W-1:0]    y_i,
  input  logic                x_sgn_i,
  input  logic                y_sgn_i,
  output logic signed [P_W-1:0] p_o
);
  logic signed [DIG_W:0] x_ext, y_ext;

  // one extra bit: sign copy for a signed digit, zero otherwise
  always_comb begin
    x_ext = $signed({x_sgn_i & x_i[DIG_W-1], x_i});
    y_ext = $signed({y_sgn_i & y_i[DIG_W-1], y_i});
    p_o   = x_ext * y_ext;
  end
endmodule

// File: rtl/mulc_pp_sum.sv
module mulc_pp_sum #(
  parameter int unsigned NDIG   = 2,
  parameter int unsigned DIG_W  = 8,
  localparam int unsigned NPP   = NDIG * NDIG,
  localparam int unsigned PP_W  = 2 * DIG_W + 2,
  localparam int unsigned PROD_W = 2 * NDIG * DIG_W
) (
  input  logic [NPP-1:0][PP_W-1:0] pp_i,
  output logic [PROD_W-1:0]        sum_o
);
  logic [NPP-1:0][PROD_W-1:0] term;

  for (genvar k = 0; k < NPP; k++) begin : g_term
    localparam int unsigned SH = mulc_pkg::pp_shift(k / NDIG, k % NDIG);
    logic [PROD_W-1:0] ext;
    assign ext     = {{(PROD_W-PP_W){pp_i[k][PP_W-1]}}, pp_i[k]};
    assign term[k] = ext << SH;
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NPP; k++) sum_o = sum_o + term[k];
  end
endmodule

// File: rtl/byte_digit_mult.sv
module byte_digit_mult #(
  parameter int unsigned OP_W    = 16,
  localparam int unsigned DIG_W  = mulc_pkg::DIG_W,
  localparam int unsigned NDIG   = OP_W / DIG_W,
  localparam int unsigned NPP    = NDIG * NDIG,
  localparam int unsigned PP_W   = 2 * DIG_W + 2,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              signed_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic              valid_o,
  output logic [PROD_W-1:0] product_o
);
  logic [NPP-1:0][PP_W-1:0] pp_d, pp_q;
  logic                     s1_vld_q;
  logic [PROD_W-1:0]        sum_d, prod_q;
  logic                     out_vld_q;

  for (genvar i = 0; i < NDIG; i++) begin : g_a
    for (genvar j = 0; j < NDIG; j++) begin : g_b
      logic signed [PP_W-1:0] p;
      // only the top digit of each operand is signed
      mulc_digit_mul #(.DIG_W(DIG_W)) u_dm (
        .x_i    (a_i[i*DIG_W +: DIG_W]),
        .y_i    (b_i[j*DIG_W +: DIG_W]),
        .x_sgn_i(signed_i && (i == NDIG - 1)),
        .y_sgn_i(signed_i && (j == NDIG - 1)),
        .p_o    (p)
      );
      assign pp_d[i*NDIG + j] = p;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_q     <= '0;
      s1_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= valid_i;
      if (valid_i) pp_q <= pp_d;
    end
  end

  mulc_pp_sum #(.NDIG(NDIG), .DIG_W(DIG_W)) u_sum (
    .pp_i (pp_q),
    .sum_o(sum_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q    <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= s1_vld_q;
      if (s1_vld_q) prod_q <= sum_d;
    end
  end

  assign valid_o   = out_vld_q;
  assign product_o = prod_q;
endmodule

// File: rtl/mulc_chk.sv
module mulc_chk #(
  parameter int unsigned OP_W = 16,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              signed_i,
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic              s1_vld_q,
  input logic              valid_o,
  input logic [PROD_W-1:0] product_o
);
  logic signed [PROD_W-1:0] a_w, b_w, ref_w;
  always_comb begin
    a_w   = signed_i ? {{OP_W{a_i[OP_W-1]}}, a_i} : {{OP_W{1'b0}}, a_i};
    b_w   = signed_i ? {{OP_W{b_i[OP_W-1]}}, b_i} : {{OP_W{1'b0}}, b_i};
    ref_w = a_w * b_w;
  end

  // R3
  stage1_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_vld_q);
  // R3
  stage1_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !s1_vld_q);
  // R3
  out_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld_q |=> valid_o);
  // R1 R2 R7
  product_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 (product_o == $past(ref_w, 2)));
  // R4
  product_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_vld_q |=> $stable(product_o));
endmodule

bind byte_digit_mult mulc_chk #(.OP_W(OP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .signed_i (signed_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .s1_vld_q (s1_vld_q),
  .valid_o  (valid_o),
  .product_o(product_o)
);

// File: tb/byte_digit_mult_tb_top.sv
module byte_digit_mult_tb_top;
  localparam int NV = 14;
  // {signed, a, b, expected}
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 16'h8000, 16'h8000, 32'h4000_0000},
    {1'b1, 16'hFFFF, 16'hFFFF, 32'h0000_0001},
    {1'b0, 16'hFFFF, 16'hFFFF, 32'hFFFE_0001},
    {1'b0, 16'h8000, 16'h8000, 32'h4000_0000},
    {1'b1, 16'h8000, 16'h0001, 32'hFFFF_8000},
    {1'b0, 16'h8000, 16'h0001, 32'h0000_8000},
    {1'b1, 16'h0003, 16'hFFFE, 32'hFFFF_FFFA},
    {1'b0, 16'h1234, 16'h0010, 32'h0001_2340},
    {1'b1, 16'h7FFF, 16'h7FFF, 32'h3FFF_0001},
    {1'b1, 16'h7FFF, 16'h8000, 32'hC000_8000},
    {1'b1, 16'h00FF, 16'hFF00, 32'hFFFF_0100},
    {1'b0, 16'h00FF, 16'hFF00, 32'h00FE_0100},
    {1'b1, 16'h0000, 16'h8000, 32'h0000_0000},
    {1'b1, 16'hFF80, 16'h0080, 32'hFFFF_C000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic        valid_o;
  logic [31:0] product_o;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  byte_digit_mult #(.OP_W(16)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .signed_i(signed_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .product_o(product_o)
  );

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic s, logic [15:0] a, logic [15:0] b);
    valid_i = v; signed_i = s; a_i = a; b_i = b;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R5 reset state
    repeat (3) @(negedge clk_i);
    check("R5", {valid_o, product_o}, 33'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R5", {valid_o, product_o}, 33'h0);

    // R1 R2 R6 R7 R3: table issued back to back, result two cycles later
    for (int k = 0; k < NV + 2; k++) begin
      if (k >= 2)
        check("R1/R2/R6/R7 vector", {valid_o, product_o}, {1'b1, VEC[k-2][31:0]});
      if (k < NV) drive(1'b1, VEC[k][64], VEC[k][63:48], VEC[k][47:32]);
      else        drive(1'b0, 1'b0, 16'h0, 16'h0);
      @(negedge clk_i);
    end
    // R3 pipeline drains
    check("R3 drain", {32'h0, valid_o}, 33'h0);

    // R4: idle operands do not change the held product
    drive(1'b0, 1'b1, 16'h1111, 16'h2222);
    repeat (3) @(negedge clk_i);
    check("R4 hold", {valid_o, product_o}, {1'b0, 32'hFFFF_C000});

    // R3 isolated latency
    drive(1'b1, 1'b0, 16'h0102, 16'h0304);
    @(negedge clk_i);
    drive(1'b0, 1'b0, 16'hABCD, 16'hABCD);
    check("R3 lat1", {32'h0, valid_o}, 33'h0);
    @(negedge clk_i);
    check("R3 lat2", {valid_o, product_o}, {1'b1, 32'h0003_0A08});
    @(negedge clk_i);
    check("R3 lat3", {valid_o, product_o}, {1'b0, 32'h0003_0A08});

    // R6 unsigned extreme in isolation
    drive(1'b1, 1'b0, 16'hFFFF, 16'hFFFF);
    @(negedge clk_i);
    drive(1'b0, 1'b0, 16'h0, 16'h0);
    @(negedge clk_i);
    check("R6 unsigned max", {valid_o, product_o}, {1'b1, 32'hFFFE_0001});

    // R5 reset clears a held result
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R5 mid reset", {valid_o, product_o}, 33'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule